// File: doc/BRIEF.md
# Voice Group Playlist Sequencer

This block plays one voice group by walking a pooled playlist table. A group is an ordered list of memory block numbers. Repeats are allowed within a group, and any block may also appear in other groups. Every group draws its entries from one shared table of up to 960 slots, and a single group may use all of them. A small descriptor table gives each group a first slot and a slot count. Both tables sit in synchronous-read arrays. They are filled through a plain configuration write port before playback.

Playback starts when a start strobe arrives with a 4-bit group code. The sequencer then fetches the group's entries one at a time. For each entry it presents a block request to the audio decoder, carrying the 7-bit block number and that block's busy attribute. It holds the request until the decoder reports that the block is done. After the last block it emits a one-cycle group-done pulse. A stop input abandons playback at any point and returns the sequencer to idle.

Reset is asynchronous and active low. It is released through a two-stage synchronizer inside the block.

Top module: `playlist_seq`

## Requirements
- R1: While reset is applied and after it is released, `blk_req`, `playing` and `grp_done` are low.
- R2: In idle, a start strobe with a group code from 0 to 13 is accepted. `playing` rises after that clock edge. `blk_req` for the group's first entry rises after the third clock edge counted from the accepting edge, and it stays low after the second.
- R3: The entries of a group are requested in slot order, from its first slot through first slot plus count minus one. Each request presents `blk_idx` = entry bits [6:0] and `blk_busy` = entry bit 7. Repeated and shared block numbers are played as written.
- R4: `blk_req` stays high, with `blk_idx` and `blk_busy` unchanged, until a clock edge at which `blk_done` is high. After a handshake edge that is not the last one, `blk_req` is low for exactly one cycle and then rises with the next entry.
- R5: At the handshake edge of a group's last entry, `grp_done` is raised for exactly one cycle, and `playing` and `blk_req` fall at the same edge.
- R6: A group whose count is zero raises `grp_done` after the second edge counted from the accepting edge, and issues no block request.
- R7: A start strobe with group code 14 or 15 is ignored. The sequencer stays idle and issues no request and no done pulse.
- R8: A start strobe received while a group is playing is ignored. The current group finishes unchanged, and afterwards the sequencer returns to idle.
- R9: `stop` high at a clock edge returns the sequencer to idle at that edge from any state. `blk_req` and `playing` go low and no `grp_done` is produced. A start in the same cycle as `stop` is not accepted. A later start plays normally.
- R10: A configuration write with `cfg_tbl`=0 stores `cfg_wdata[7:0]` as the entry at slot `cfg_addr`. A write with `cfg_tbl`=1 stores a descriptor for group `cfg_addr[3:0]`, with the first slot in `cfg_wdata[9:0]` and the count in `cfg_wdata[19:10]`.
- R11: `playing` stays high from the accepting edge until the edge that returns the sequencer to idle. `blk_req` is never high while `playing` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_tbl | input | 1 | Write target: 0 entry table, 1 descriptor table |
| cfg_addr | input | 10 | Entry slot or group code for the write |
| cfg_wdata | input | 20 | Write data |
| start | input | 1 | Start strobe |
| start_grp | input | 4 | Group code to play |
| stop | input | 1 | Abort playback |
| blk_done | input | 1 | Decoder finished the requested block |
| blk_req | output | 1 | Block request to the decoder |
| blk_idx | output | 7 | Requested block number |
| blk_busy | output | 1 | Busy attribute of the requested block |
| playing | output | 1 | A group is in progress |
| grp_done | output | 1 | One-cycle pulse at group completion |

## Verification
The assertions assume three things about the inputs. First, the decoder raises `blk_done` only while a request is outstanding. Second, the descriptor tables are written only while the sequencer is idle. Third, every group's first slot plus its count stays within the 960-slot table. The stimulus keeps to these assumptions in the following way. It loads the whole table once, before any start. It answers each request with a single-cycle `blk_done` after a wait of zero to three cycles. The last group it configures ends exactly at slot 959.

// File: rtl/playlist_pkg.sv
package playlist_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_DESC  = 2'd1,
    S_FETCH = 2'd2,
    S_REQ   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/playlist_ram.sv
module playlist_ram #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 960,
  parameter int AW    = 10
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  localparam logic [AW:0] DEPTH_L = DEPTH[AW:0];

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rdata_q;
  logic             wr_ok;

  assign wr_ok = we && ({1'b0, waddr} < DEPTH_L);

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (re) begin
      rdata_q <= mem[raddr];
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/playlist_fsm.sv
module playlist_fsm
  import playlist_pkg::*;
#(
  parameter int NUM_GROUPS = 14,
  parameter int GRP_W      = 4,
  parameter int BLK_W      = 7,
  parameter int IDX_W      = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [GRP_W-1:0]   start_grp,
  input  logic               stop,
  input  logic               blk_done,
  output logic               desc_re,
  output logic [GRP_W-1:0]   desc_raddr,
  input  logic [2*IDX_W-1:0] desc_rdata,
  output logic               ent_re,
  output logic [IDX_W-1:0]   ent_raddr,
  input  logic [BLK_W:0]     ent_rdata,
  output logic               blk_req,
  output logic [BLK_W-1:0]   blk_idx,
  output logic               blk_busy,
  output logic               playing,
  output logic               grp_done
);
  localparam logic [GRP_W:0] GRP_LIM = NUM_GROUPS[GRP_W:0];
  localparam logic [IDX_W-1:0] ONE   = IDX_W'(1);

  seq_state_t       state_q, state_n;
  logic [IDX_W-1:0] ptr_q, ptr_n;
  logic [IDX_W-1:0] left_q, left_n;
  logic             req_q, req_n;
  logic             done_q, done_n;
  logic [BLK_W-1:0] idx_q;
  logic             busy_q;
  logic             ld_en, out_en, grp_ok;
  logic [IDX_W-1:0] desc_first, desc_cnt;

  assign desc_first = desc_rdata[IDX_W-1:0];
  assign desc_cnt   = desc_rdata[2*IDX_W-1:IDX_W];
  assign grp_ok     = ({1'b0, start_grp} < GRP_LIM);
  assign desc_raddr = start_grp;
  assign ent_raddr  = (state_q == S_DESC) ? desc_first : ptr_q;

  always_comb begin
    state_n = state_q;
    ptr_n   = ptr_q;
    left_n  = left_q;
    req_n   = req_q;
    done_n  = 1'b0;
    ld_en   = 1'b0;
    out_en  = 1'b0;
    desc_re = 1'b0;
    ent_re  = 1'b0;
    if (stop) begin
      state_n = S_IDLE;
      req_n   = 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (start && grp_ok) begin
            desc_re = 1'b1;
            state_n = S_DESC;
          end
        end
        S_DESC: begin
          if (desc_cnt == '0) begin
            done_n  = 1'b1;
            state_n = S_IDLE;
          end else begin
            ent_re  = 1'b1;
            ld_en   = 1'b1;
            ptr_n   = desc_first + ONE;
            left_n  = desc_cnt;
            state_n = S_FETCH;
          end
        end
        S_FETCH: begin
          out_en  = 1'b1;
          req_n   = 1'b1;
          state_n = S_REQ;
        end
        S_REQ: begin
          if (blk_done) begin
            req_n = 1'b0;
            if (left_q == ONE) begin
              done_n  = 1'b1;
              state_n = S_IDLE;
            end else begin
              ent_re  = 1'b1;
              ld_en   = 1'b1;
              ptr_n   = ptr_q + ONE;
              left_n  = left_q - ONE;
              state_n = S_FETCH;
            end
          end
        end
        default: state_n = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      req_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      req_q   <= req_n;
      done_q  <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      left_q <= '0;
    end else if (ld_en) begin
      ptr_q  <= ptr_n;
      left_q <= left_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else if (out_en) begin
      idx_q  <= ent_rdata[BLK_W-1:0];
      busy_q <= ent_rdata[BLK_W];
    end
  end

  assign blk_req  = req_q;
  assign blk_idx  = idx_q;
  assign blk_busy = busy_q;
  assign playing  = (state_q != S_IDLE);
  assign grp_done = done_q;
endmodule

// File: rtl/playlist_seq.sv
module playlist_seq #(
  parameter int NUM_GROUPS = 14,
  parameter int GRP_W      = 4,
  parameter int BLK_W      = 7,
  parameter int ENTRIES    = 960,
  parameter int IDX_W      = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_tbl,
  input  logic [IDX_W-1:0]   cfg_addr,
  input  logic [2*IDX_W-1:0] cfg_wdata,
  input  logic               start,
  input  logic [GRP_W-1:0]   start_grp,
  input  logic               stop,
  input  logic               blk_done,
  output logic               blk_req,
  output logic [BLK_W-1:0]   blk_idx,
  output logic               blk_busy,
  output logic               playing,
  output logic               grp_done
);
  localparam int DESC_W = 2 * IDX_W;
  localparam int ENT_W  = BLK_W + 1;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             desc_re, ent_re;
  logic [GRP_W-1:0] desc_raddr;
  logic [IDX_W-1:0] ent_raddr;
  logic [DESC_W-1:0] desc_rdata;
  logic [ENT_W-1:0] ent_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  playlist_ram #(.WIDTH(DESC_W), .DEPTH(NUM_GROUPS), .AW(GRP_W)) u_desc (
    .clk   (clk),
    .we    (cfg_we && cfg_tbl),
    .waddr (cfg_addr[GRP_W-1:0]),
    .wdata (cfg_wdata),
    .re    (desc_re),
    .raddr (desc_raddr),
    .rdata (desc_rdata)
  );

  playlist_ram #(.WIDTH(ENT_W), .DEPTH(ENTRIES), .AW(IDX_W)) u_ent (
    .clk   (clk),
    .we    (cfg_we && !cfg_tbl),
    .waddr (cfg_addr),
    .wdata (cfg_wdata[ENT_W-1:0]),
    .re    (ent_re),
    .raddr (ent_raddr),
    .rdata (ent_rdata)
  );

  playlist_fsm #(
    .NUM_GROUPS(NUM_GROUPS), .GRP_W(GRP_W), .BLK_W(BLK_W), .IDX_W(IDX_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (start),
    .start_grp  (start_grp),
    .stop       (stop),
    .blk_done   (blk_done),
    .desc_re    (desc_re),
    .desc_raddr (desc_raddr),
    .desc_rdata (desc_rdata),
    .ent_re     (ent_re),
    .ent_raddr  (ent_raddr),
    .ent_rdata  (ent_rdata),
    .blk_req    (blk_req),
    .blk_idx    (blk_idx),
    .blk_busy   (blk_busy),
    .playing    (playing),
    .grp_done   (grp_done)
  );
endmodule

// File: rtl/playlist_seq_chk.sv
module playlist_seq_chk #(
  parameter int NUM_GROUPS = 14,
  parameter int GRP_W      = 4,
  parameter int BLK_W      = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [GRP_W-1:0] start_grp,
  input logic             stop,
  input logic             blk_done,
  input logic             blk_req,
  input logic [BLK_W-1:0] blk_idx,
  input logic             blk_busy,
  input logic             playing,
  input logic             grp_done
);
  localparam logic [GRP_W:0] GRP_LIM = NUM_GROUPS[GRP_W:0];

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_req && !blk_done && !stop) |=> (blk_req && $stable(blk_idx) && $stable(blk_busy))); // R4
  AST_REQ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_req && blk_done) |=> !blk_req); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    grp_done |=> !grp_done); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    grp_done |-> (!playing && !blk_req)); // R5
  AST_STOP_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!playing && !blk_req && !grp_done)); // R9
  AST_REQ_PLAYING: assert property (@(posedge clk) disable iff (!rst_n)
    blk_req |-> playing); // R11
  AST_BAD_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (!playing && start && ({1'b0, start_grp} >= GRP_LIM)) |=> !playing); // R7
endmodule

bind playlist_seq playlist_seq_chk #(
  .NUM_GROUPS(NUM_GROUPS), .GRP_W(GRP_W), .BLK_W(BLK_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .start_grp (start_grp),
  .stop      (stop),
  .blk_done  (blk_done),
  .blk_req   (blk_req),
  .blk_idx   (blk_idx),
  .blk_busy  (blk_busy),
  .playing   (playing),
  .grp_done  (grp_done)
);

// File: tb/playlist_seq_bench.sv
module playlist_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_tbl = 1'b0;
  logic [9:0]  cfg_addr = '0;
  logic [19:0] cfg_wdata = '0;
  logic        start = 1'b0;
  logic [3:0]  start_grp = '0;
  logic        stop = 1'b0;
  logic        blk_done = 1'b0;
  logic        blk_req, blk_busy, playing, grp_done;
  logic [6:0]  blk_idx;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  playlist_seq u_playlist_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_tbl(cfg_tbl),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .start(start),
    .start_grp(start_grp), .stop(stop), .blk_done(blk_done),
    .blk_req(blk_req), .blk_idx(blk_idx), .blk_busy(blk_busy),
    .playing(playing), .grp_done(grp_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ent_val(input int a);
    int blk;
    if (a == 240 || a == 241) blk = 10;
    else if (a == 242) blk = 5;
    else blk = (a * 37 + a / 3) % 126;
    return ((a % 3 == 0) ? 128 : 0) + blk;
  endfunction

  function automatic int g_first(input int g);
    if (g == 13) return 900;
    if (g == 12) return 240;
    if (g == 11) return 20;
    return g * 20;
  endfunction

  function automatic int g_cnt(input int g);
    if (g == 13) return 60;
    if (g == 12) return 3;
    return g % 6;
  endfunction

  task automatic idle_quiet(input int cycles, input string req);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk(!playing && !blk_req && !grp_done, req, {playing, blk_req, grp_done}, 0);
    end
  endtask

  task automatic play(input int g, input bit poke);
    int first = g_first(g);
    int n = g_cnt(g);
    @(negedge clk); start = 1'b1; start_grp = g[3:0];
    @(negedge clk); start = 1'b0;
    chk(playing == 1'b1, "R11 playing after accept", playing, 1);
    @(negedge clk);
    if (n == 0) begin
      chk(grp_done && !blk_req && !playing, "R6 empty group done", {grp_done, blk_req, playing}, 4);
      @(negedge clk);
      chk(!grp_done, "R5 done single pulse", grp_done, 0);
      return;
    end
    chk(!blk_req, "R2 no request before third edge", blk_req, 0);
    for (int k = 0; k < n; k++) begin
      int exp_v = ent_val(first + k);
      int lat = (k + g) % 4;
      @(negedge clk);
      chk(blk_req, "R2/R4 request rises", blk_req, 1);
      chk({blk_busy, blk_idx} == exp_v[7:0], "R3 entry order and fields", {blk_busy, blk_idx}, exp_v);
      for (int w = 0; w < lat; w++) begin
        if (poke && k == 1 && w == 0) begin start = 1'b1; start_grp = 4'd2; end
        @(negedge clk); start = 1'b0;
        chk(blk_req && ({blk_busy, blk_idx} == exp_v[7:0]), "R4 request held",
            {blk_req, blk_busy, blk_idx}, 256 + exp_v);
      end
      blk_done = 1'b1;
      @(negedge clk); blk_done = 1'b0;
      if (k == n - 1) begin
        chk(grp_done && !playing && !blk_req, "R5 done at last handshake",
            {grp_done, playing, blk_req}, 4);
        @(negedge clk);
        chk(!grp_done && !playing, poke ? "R8 idle after ignored start" : "R5 single pulse",
            {grp_done, playing}, 0);
      end else begin
        chk(!blk_req && playing && !grp_done, "R4 one-cycle gap", {blk_req, playing, grp_done}, 2);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!blk_req && !playing && !grp_done, "R1 in reset", {blk_req, playing, grp_done}, 0);
    rst_n = 1'b1;
    idle_quiet(4, "R1 after reset");

    // R10: load entry table and descriptors
    for (int a = 0; a < 960; a++) begin
      @(negedge clk); cfg_we = 1'b1; cfg_tbl = 1'b0; cfg_addr = a[9:0];
      cfg_wdata = 20'(ent_val(a));
    end
    for (int g = 0; g < 14; g++) begin
      @(negedge clk); cfg_we = 1'b1; cfg_tbl = 1'b1; cfg_addr = g[9:0];
      cfg_wdata = {10'(g_cnt(g)), 10'(g_first(g))};
    end
    @(negedge clk); cfg_we = 1'b0;

    // R2 R3 R4 R5 R6 R10: sweep all groups
    for (int g = 0; g < 14; g++) play(g, g == 5);

    // R7: out-of-range codes
    for (int c = 14; c < 16; c++) begin
      @(negedge clk); start = 1'b1; start_grp = c[3:0];
      @(negedge clk); start = 1'b0;
      idle_quiet(5, "R7 bad group ignored");
    end

    // R9: stop while requesting
    @(negedge clk); start = 1'b1; start_grp = 4'd13;
    @(negedge clk); start = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(blk_req, "R9 setup request", blk_req, 1);
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    chk(!playing && !blk_req && !grp_done, "R9 abort in request", {playing, blk_req, grp_done}, 0);
    idle_quiet(5, "R9 stays idle");

    // R9: stop during descriptor read
    @(negedge clk); start = 1'b1; start_grp = 4'd4;
    @(negedge clk); start = 1'b0; stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    chk(!playing, "R9 abort in descriptor", playing, 0);
    idle_quiet(5, "R9 no request after abort");

    // R9: stop beats start
    @(negedge clk); start = 1'b1; stop = 1'b1; start_grp = 4'd3;
    @(negedge clk); start = 1'b0; stop = 1'b0;
    chk(!playing, "R9 stop wins over start", playing, 0);
    idle_quiet(4, "R9 idle after tie");

    // R9: recovery
    play(4, 1'b0);
    play(12, 1'b0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule